// File: doc/BRIEF.md
# Audio Delay Line

This block holds audio back for a programmable number of sample periods so that a dynamic range compressor placed after it can settle its gain before the sound arrives. Signed 24-bit samples enter with a valid strobe. They leave one clock later, either straight through or taken from a circular sample store at a chosen distance behind the newest sample. The distance is picked by a 6-bit code in steps of eight samples and saturates at 384.

When the compressor is switched off while the delay is on, the block keeps emitting the samples it still holds. It raises a completion flag once the last one has left. A keep-buffer input then chooses whether audio keeps flowing through the store or skips it. Software clears the delay enable after seeing the flag, and that also clears the flag.

Top module: `audio_delay_line`

## Requirements
- R1: With the delay on and a code n below 0x30, each output sample equals the input sample taken 8*(n+1) valid strobes earlier. Only cycles with the valid strobe high advance the line.
- R2: Every code from 0x30 to 0x3F gives a delay of 384 valid strobes.
- R3: While the delay enable is low, each valid input sample is output unchanged one clock later, whatever the code.
- R4: After the delay is switched on, the first D outputs (D being the selected delay) are zero, not stale store contents.
- R5: The code is captured in the cycle the delay enable is first seen high. Later code changes have no effect until the enable has gone low and high again.
- R6: If the compressor enable is low while the delay is on, drain_done rises together with the output of the D-th valid strobe counted since the compressor enable went low. If the compressor enable returns high before then, the count restarts from zero. Once set, drain_done stays high while the delay enable stays high.
- R7: While drain_done is high, keep_buf=1 keeps outputs delayed by D, and keep_buf=0 passes inputs straight through one clock later.
- R8: The clock after the delay enable is seen low, drain_done is 0.
- R9: out_valid equals in_valid one clock earlier. When the valid strobe is low, out_sample holds its value.
- R10: After reset, out_valid, out_sample and drain_done are 0 and the delay is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 | Signed input sample |
| comp_en | input | 1 | Compressor enable; low starts the drain |
| dly_en | input | 1 | Delay function enable |
| dly_code | input | 6 | Delay selection code |
| keep_buf | input | 1 | After drain: 1 stay in store path, 0 skip it |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 24 | Signed output sample |
| drain_done | output | 1 | Held samples have all been sent out |

## Verification
Every result of this block is registered once: an output sample, its strobe and drain_done all appear on the edge that consumes the input strobe. A change of the delay enable or of keep_buf therefore alters the path for the sample presented in that same cycle. The bench drives each input on the falling edge and updates its queue-based model for that cycle. It then samples every output one nanosecond after the next rising edge and compares against the model on every clock. This means the delay counts, the zero-fill window and the exact clock on which drain_done rises are each checked at the single cycle where they are due.

// File: rtl/adl_pkg.sv
package adl_pkg;
  localparam int ADL_SAMPLE_W  = 24;
  localparam int ADL_CODE_W    = 6;
  localparam int ADL_STEP      = 8;
  localparam int ADL_MAX_STEPS = 48;

  typedef enum logic [1:0] {
    PATH_DIRECT  = 2'd0,
    PATH_SILENT  = 2'd1,
    PATH_DELAYED = 2'd2
  } adl_path_e;
endpackage

// File: rtl/adl_rst_sync.sv
module adl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/adl_sample_ram.sv
module adl_sample_ram #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 384,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // Read-before-write: at full depth the read hits the slot being overwritten.
  assign rd_data = store[rd_addr];
endmodule

// File: rtl/adl_delay_ctrl.sv
module adl_delay_ctrl #(
  parameter int CODE_W    = 6,
  parameter int STEP      = 8,
  parameter int MAX_STEPS = 48,
  localparam int DEPTH    = STEP * MAX_STEPS,
  localparam int AW       = $clog2(DEPTH),
  localparam int DW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              comp_en,
  input  logic              dly_en,
  input  logic [CODE_W-1:0] dly_code,
  output logic              armed,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     rd_addr,
  output logic              filled,
  output logic              done
);
  logic          armed_q, armed_d;
  logic [DW-1:0] span_q, span_d;
  logic [AW-1:0] wptr_q, wptr_d;
  logic [DW-1:0] fill_q, fill_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          done_q, done_d;
  logic          arm_start, drain_act;
  logic [DW-1:0] span_sel;
  logic [DW:0]   w_ext, s_ext;

  // Code to delay in samples, saturating at the store depth.
  always_comb begin
    if (int'(dly_code) >= MAX_STEPS) span_sel = DW'(DEPTH);
    else                             span_sel = DW'((int'(dly_code) + 1) * STEP);
  end

  assign arm_start = dly_en & ~armed_q;
  assign drain_act = armed_q & dly_en & ~comp_en & ~done_q;

  always_comb begin
    armed_d = dly_en;
    span_d  = span_q;
    wptr_d  = wptr_q;
    fill_d  = fill_q;
    dcnt_d  = dcnt_q;
    done_d  = done_q;
    if (!dly_en || arm_start) begin
      wptr_d = '0;
      fill_d = '0;
      dcnt_d = '0;
      done_d = 1'b0;
      if (arm_start) span_d = span_sel;
    end else begin
      if (in_valid) begin
        wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
        if (fill_q < span_q) fill_d = fill_q + DW'(1);
      end
      if (comp_en) begin
        dcnt_d = '0;
      end else if (drain_act && in_valid) begin
        if (dcnt_q == span_q - DW'(1)) begin
          dcnt_d = '0;
          done_d = 1'b1;
        end else begin
          dcnt_d = dcnt_q + DW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      span_q  <= DW'(STEP);
      wptr_q  <= '0;
      fill_q  <= '0;
      dcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      span_q  <= span_d;
      wptr_q  <= wptr_d;
      fill_q  <= fill_d;
      dcnt_q  <= dcnt_d;
      done_q  <= done_d;
    end
  end

  assign w_ext = {{(DW + 1 - AW){1'b0}}, wptr_q};
  assign s_ext = {1'b0, span_q};

  always_comb begin
    if (w_ext >= s_ext) rd_addr = AW'(w_ext - s_ext);
    else                rd_addr = AW'(w_ext + (DW + 1)'(DEPTH) - s_ext);
  end

  assign armed   = armed_q;
  assign wr_en   = in_valid & armed_q & dly_en;
  assign wr_addr = wptr_q;
  assign filled  = (fill_q == span_q);
  assign done    = done_q;
endmodule

// File: rtl/audio_delay_line.sv
module audio_delay_line
  import adl_pkg::*;
#(
  parameter int SAMPLE_W  = ADL_SAMPLE_W,
  parameter int CODE_W    = ADL_CODE_W,
  parameter int STEP      = ADL_STEP,
  parameter int MAX_STEPS = ADL_MAX_STEPS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  input  logic                       comp_en,
  input  logic                       dly_en,
  input  logic        [CODE_W-1:0]   dly_code,
  input  logic                       keep_buf,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_sample,
  output logic                       drain_done
);
  localparam int DEPTH = STEP * MAX_STEPS;
  localparam int AW    = $clog2(DEPTH);

  logic                rst_sync_n;
  logic                armed, wr_en, filled, done;
  logic [AW-1:0]       wr_addr, rd_addr;
  logic [SAMPLE_W-1:0] rd_data;
  adl_path_e           path;
  logic                ovld_d;
  logic [SAMPLE_W-1:0] osmp_d, osmp_q;

  adl_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  adl_delay_ctrl #(
    .CODE_W   (CODE_W),
    .STEP     (STEP),
    .MAX_STEPS(MAX_STEPS)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_valid(in_valid),
    .comp_en (comp_en),
    .dly_en  (dly_en),
    .dly_code(dly_code),
    .armed   (armed),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .filled  (filled),
    .done    (done)
  );

  adl_sample_ram #(
    .WIDTH(SAMPLE_W),
    .DEPTH(DEPTH)
  ) u_ram (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(in_sample),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  always_comb begin
    if (!dly_en || !armed || (done && !keep_buf)) path = PATH_DIRECT;
    else if (!filled)                             path = PATH_SILENT;
    else                                          path = PATH_DELAYED;
  end

  always_comb begin
    ovld_d = in_valid;
    osmp_d = osmp_q;
    if (in_valid) begin
      unique case (path)
        PATH_DIRECT:  osmp_d = in_sample;
        PATH_SILENT:  osmp_d = '0;
        PATH_DELAYED: osmp_d = rd_data;
        default:      osmp_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      osmp_q    <= '0;
    end else begin
      out_valid <= ovld_d;
      osmp_q    <= osmp_d;
    end
  end

  assign out_sample = osmp_q;
  assign drain_done = done;
endmodule

// File: rtl/adl_checker.sv
module adl_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_sample,
  input logic                comp_en,
  input logic                dly_en,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_sample,
  input logic                drain_done
);
  logic started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    started && in_valid |=> out_valid);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    started && !in_valid |=> !out_valid && $stable(out_sample));

  a_r3_direct_path: assert property (@(posedge clk) disable iff (!rst_n)
    started && in_valid && !dly_en |=> out_sample == $past(in_sample));

  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    started && !dly_en |=> !drain_done);

  a_r6_done_from_drain: assert property (@(posedge clk) disable iff (!rst_n)
    started && $rose(drain_done) |-> $past(!comp_en) && $past(in_valid));

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    started && drain_done && dly_en |=> drain_done);
endmodule

bind audio_delay_line adl_checker #(.SAMPLE_W(SAMPLE_W)) u_adl_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .comp_en   (comp_en),
  .dly_en    (dly_en),
  .out_valid (out_valid),
  .out_sample(out_sample),
  .drain_done(drain_done)
);

// File: tb/test_audio_delay_line.sv
`timescale 1ns/1ps
module test_audio_delay_line;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [23:0] in_sample = '0;
  logic               comp_en = 1'b1;
  logic               dly_en = 1'b0;
  logic [5:0]         dly_code = '0;
  logic               keep_buf = 1'b1;
  logic               out_valid;
  logic signed [23:0] out_sample;
  logic               drain_done;

  always #2 clk = ~clk;

  audio_delay_line i_audio_delay_line (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .comp_en(comp_en), .dly_en(dly_en), .dly_code(dly_code), .keep_buf(keep_buf),
    .out_valid(out_valid), .out_sample(out_sample), .drain_done(drain_done)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string cur_req = "R3";

  // Behavioural reference state
  logic signed [23:0] hist[$];
  bit                 m_armed = 0;
  bit                 m_done = 0;
  int                 m_span = 8;
  int                 m_dcnt = 0;
  bit                 e_valid = 0;
  logic signed [23:0] e_sample = '0;

  bit b_ce = 1, b_de = 0, b_kb = 1;
  logic [5:0] b_code = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input bit v, input logic signed [23:0] x);
    bit direct;
    @(negedge clk);
    in_valid = v; in_sample = x;
    comp_en = b_ce; dly_en = b_de; dly_code = b_code; keep_buf = b_kb;
    direct = !b_de || !m_armed || (m_done && !b_kb);
    e_valid = v;
    if (v) begin
      if (direct)                     e_sample = x;
      else if (hist.size() >= m_span) e_sample = hist[hist.size() - m_span];
      else                            e_sample = '0;
    end
    if (!b_de) begin
      m_armed = 0; m_done = 0; m_dcnt = 0; hist.delete();
    end else if (!m_armed) begin
      m_armed = 1; m_done = 0; m_dcnt = 0; hist.delete();
      m_span = (b_code > 6'd47) ? 384 : 8 * int'(b_code) + 8;
    end else begin
      if (v) begin
        hist.push_back(x);
        if (hist.size() > m_span) void'(hist.pop_front());
      end
      if (b_ce) m_dcnt = 0;
      else if (!m_done && v) begin
        m_dcnt++;
        if (m_dcnt == m_span) begin m_done = 1; m_dcnt = 0; end
      end
    end
    @(posedge clk);
    #1;
    check(out_valid == e_valid, "R9", "out_valid", out_valid, e_valid);
    if (e_valid)
      check(out_sample == e_sample, cur_req, "out_sample", out_sample, e_sample);
    check(drain_done == m_done, m_done ? "R6" : "R8", "drain_done", drain_done, m_done);
  endtask

  task automatic stream(input int n, input int gap_pct);
    for (int i = 0; i < n; i++)
      tick(($urandom_range(99) >= gap_pct), 24'($urandom));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick(0, '0);
    // R10: reset state
    check(out_valid == 0 && out_sample == 0 && drain_done == 0, "R10", "reset outputs",
          {out_valid, drain_done, out_sample}, 0);

    // R3: direct path, code ignored
    cur_req = "R3";
    for (int i = 0; i < 30; i++) begin
      b_code = 6'($urandom);
      tick($urandom_range(1), 24'($urandom));
    end

    // R4 then R1: code 0 gives 8, with strobe gaps
    cur_req = "R4"; b_code = 6'h00; b_de = 1;
    stream(12, 25);
    cur_req = "R1";
    stream(60, 25);

    // R1: code 5 gives 48
    b_de = 0; tick(1, 24'sd77);
    b_code = 6'h05; b_de = 1; cur_req = "R1";
    stream(160, 30);

    // R2: saturated codes
    b_de = 0; tick(0, '0);
    b_code = 6'h3A; b_de = 1; cur_req = "R2";
    stream(900, 5);
    b_de = 0; tick(0, '0);
    b_code = 6'h30; b_de = 1; cur_req = "R2";
    stream(800, 0);

    // R5: code change while armed has no effect
    b_de = 0; tick(0, '0);
    b_code = 6'h01; b_de = 1; cur_req = "R5";
    tick(1, 24'sd5);
    b_code = 6'h3F;
    stream(60, 10);

    // R6: drain with keep_buf=1, then R7 for both keep_buf values
    cur_req = "R6"; b_ce = 0; b_kb = 1;
    stream(30, 30);
    check(drain_done == 1, "R6", "drain complete", drain_done, 1);
    cur_req = "R7";
    stream(25, 20);
    b_kb = 0;
    stream(25, 20);
    b_ce = 1;
    stream(5, 0);
    // R8: clearing the enable clears the flag
    b_de = 0; cur_req = "R3";
    tick(1, 24'sd9);
    check(drain_done == 0, "R8", "flag cleared", drain_done, 0);

    // R6: interrupted drain restarts the count
    b_code = 6'h01; b_de = 1; b_kb = 1; cur_req = "R6";
    stream(30, 0);
    b_ce = 0; stream(8, 0);
    b_ce = 1; stream(5, 0);
    b_ce = 0; stream(15, 0);
    check(drain_done == 0, "R6", "restart not yet done", drain_done, 0);
    stream(3, 0);
    check(drain_done == 1, "R6", "restart done", drain_done, 1);

    // R6 with R4: drain begun before the line filled
    b_de = 0; b_ce = 1; tick(0, '0);
    b_code = 6'h02; b_de = 1; b_ce = 0; b_kb = 0; cur_req = "R4";
    stream(40, 15);
    b_de = 0; b_ce = 1; tick(1, 24'sd3);

    finish_run();
  end
endmodule